// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel is a pair of byte registers, a low byte and a high byte, and has its own configuration: a two-bit mode, a select between machine-cycle timing and external event counting, a gate enable and a run bit. Each channel also has a sticky overflow flag. All machine-cycle activity follows a one-clock `mc_en` strobe supplied by the surrounding core. The external count pins and gate pins are assumed to be already synchronous to `clk`.

Software, or the core, loads and reads the count bytes and the configuration through a flat byte-wide register port. Each overflow flag is cleared either by a configuration write or by a per-channel acknowledge input. Channel 1's own wrap leaves the block as a one-cycle tick. A neighbouring rate generator can use it even while channel 0 has taken channel 1's flag in split mode.

Top module: `tmr_pair`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears every count byte, every configuration field, both overflow flags and the tick output to zero.
- R2: Mode 1 treats {high, low} as one 16-bit count. Wrapping from FFFF to 0000 sets the channel's flag.
- R3: Mode 0 is a 13-bit count: the low 5 bits of the low byte form a prescaler below the 8-bit high byte. The upper 3 bits of the low byte keep their value. The flag sets when all 13 bits wrap to zero.
- R4: Mode 2 counts the low byte alone. When it would pass FF, it reloads from the high byte and sets the flag. The high byte never changes by counting.
- R5: With counter select 0 (timer), a running channel advances by one on each cycle with mc_en high. The external count pin has no effect.
- R6: With counter select 1, the count advances on a cycle with mc_en high when the pin was 1 at the previous mc_en sample and is 0 at this one. A pulse that is never sampled is not counted.
- R7: A channel counts only while run=1 and either gate=0 or its external gate input is 1.
- R8: In channel 0 mode 3, the low byte is an 8-bit count under channel 0's own run, gate and select, and it sets flag 0 on wrap. Channel 0's high byte is a timer only: it advances on mc_en whenever channel 1's run bit is 1, and its wrap sets flag 1.
- R9: While channel 0 is in mode 3, channel 1 keeps counting in its own mode and its wrap still pulses ch1_tick for one cycle, but it does not set flag 1.
- R10: A flag stays set until int_ack for that channel is high or its configuration byte is written with bit 5 = 0. If a wrap and a clear meet in one cycle, the flag ends set.
- R11: A write to a count byte in the same cycle as an increment leaves the written value in that byte.
- R12: Channel 1 in mode 3 holds both of its bytes.
- R13: Register map: address 0/1 are channel 0 low/high, 2/3 are channel 1 low/high, 4/5 are channel 0/1 configuration. Configuration bits are [1:0] mode (0=13-bit, 1=16-bit, 2=reload, 3=split), [2] counter select, [3] gate, [4] run, [5] flag (reads the flag). Other addresses and bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_en | input | 1 | Machine-cycle strobe, one clock wide |
| ext_cnt | input | 2 | External count pins, bit i for channel i |
| ext_gate | input | 2 | External gate inputs, bit i for channel i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| int_ack | input | 2 | Per-channel flag clear |
| ovf_flag | output | 2 | Sticky overflow flags |
| ch1_tick | output | 1 | One-cycle pulse on channel 1's own wrap |

## Verification
Two collisions get the most attention. The first is a flag that wraps in the same cycle as its clear, done once through the acknowledge input and once through a configuration write. The bench drives mc_en together with the clear in a single cycle, starting from a reload-mode count of FF, and expects the flag to read 1 afterwards. The second is a count-byte write that lands on an increment cycle. There the written byte must survive with neither the old value nor the written value plus one. Split mode is judged on its own collision as well: channel 1 wraps while channel 0's high byte does not, so the tick must pulse while flag 1 stays clear.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual timer/counter.
// Assumes: mode codes are decoded by software, so their values are fixed.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_PRESC  = 2'd0,   // 13-bit: 5-bit prescaler under 8-bit high byte
        MODE_WIDE   = 2'd1,   // full 16-bit
        MODE_RELOAD = 2'd2,   // 8-bit with reload from high byte
        MODE_SPLIT  = 2'd3    // channel 0: two 8-bit counts; channel 1: hold
    } tmr_mode_e;

    typedef struct packed {
        logic      run;
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;

    localparam int CFG_W   = 5;
    localparam int FLAG_BIT = 5;

endpackage

// File: rtl/tmr_fall_detect.sv
`timescale 1ns/1ps
// Falling-edge detector for an external count pin sampled on machine cycles.
// Assumes: pin is already synchronous to clk. An event needs two consecutive
// mc_en samples, the first 1 and the second 0.
module tmr_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic pin,
    output logic fall
);

    logic last_smp;

    // Keep the pin value seen at the previous machine-cycle sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_smp <= 1'b0;
        else if (smp_en) last_smp <= pin;
    end

    // Event when the previous sample was high and this one is low.
    assign fall = smp_en & last_smp & ~pin;

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One timer/counter channel: low and high byte with the four count modes.
// Assumes: step/aux_step are already gated (run, gate, source) by the parent.
// HAS_SPLIT=1 makes mode 3 a pair of 8-bit counts; HAS_SPLIT=0 makes it hold.
// Requires PRESC_W < BYTE_W.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int PRESC_W   = 5,
    parameter bit HAS_SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              step,
    input  logic              aux_step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              wrap,
    output logic              aux_wrap
);

    localparam int                 WIDE_W = 2 * BYTE_W;
    localparam logic [WIDE_W-1:0]  W_ONE  = WIDE_W'(1);
    localparam logic [BYTE_W-1:0]  B_ONE  = BYTE_W'(1);
    localparam logic [PRESC_W:0]   P_ONE  = (PRESC_W+1)'(1);

    logic [BYTE_W-1:0]  lo_n, hi_n;
    logic [PRESC_W:0]   psum;
    logic [WIDE_W-1:0]  wsum;

    assign psum = {1'b0, lo_q[PRESC_W-1:0]} + P_ONE;
    assign wsum = {hi_q, lo_q} + W_ONE;

    // Next-state of both bytes for the selected mode; writes take priority.
    always_comb begin
        lo_n     = lo_q;
        hi_n     = hi_q;
        wrap     = 1'b0;
        aux_wrap = 1'b0;
        unique case (mode)
            MODE_PRESC: if (step) begin
                lo_n = {lo_q[BYTE_W-1:PRESC_W], psum[PRESC_W-1:0]};
                if (psum[PRESC_W]) begin
                    hi_n = hi_q + B_ONE;
                    wrap = &hi_q;
                end
            end
            MODE_WIDE: if (step) begin
                {hi_n, lo_n} = wsum;
                wrap = &{hi_q, lo_q};
            end
            MODE_RELOAD: if (step) begin
                if (&lo_q) begin
                    lo_n = hi_q;
                    wrap = 1'b1;
                end else begin
                    lo_n = lo_q + B_ONE;
                end
            end
            MODE_SPLIT: if (HAS_SPLIT) begin
                if (step) begin
                    lo_n = lo_q + B_ONE;
                    wrap = &lo_q;
                end
                if (aux_step) begin
                    hi_n     = hi_q + B_ONE;
                    aux_wrap = &hi_q;
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // A written byte holds the written value, not value plus one.
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> lo_q == $past(wr_data));

    // Reload mode: a full low byte takes the high byte on the next step.
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && step && (&lo_q) && !wr_lo && !wr_hi)
        |=> lo_q == $past(hi_q));

    // No enabled step and no write leaves both bytes unchanged.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !aux_step && !wr_lo && !wr_hi)
        |=> ($stable(lo_q) && $stable(hi_q)));

    generate
        if (!HAS_SPLIT) begin : g_hold_chk
            // Mode 3 on a channel without split freezes its count.
            assert_split_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MODE_SPLIT && !wr_lo && !wr_hi)
                |=> ($stable(lo_q) && $stable(hi_q)));
        end
    endgenerate

endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
// Two timer/counter channels with configuration, sticky flags and a register
// port. Channel 0 may split into two 8-bit counts, borrowing channel 1's run
// bit and flag. Assumes ext_cnt, ext_gate and int_ack are synchronous to clk.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PRESC_W = 5,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic [1:0]        ext_cnt,
    input  logic [1:0]        ext_gate,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        int_ack,
    output logic [1:0]        ovf_flag,
    output logic              ch1_tick
);

    localparam int NCH = 2;

    tmr_cfg_t          cfg_q   [NCH];
    logic [BYTE_W-1:0] lo_q    [NCH];
    logic [BYTE_W-1:0] hi_q    [NCH];
    logic [NCH-1:0]    fall, step, aux_step, wrap, aux_wrap;
    logic [NCH-1:0]    wr_lo, wr_hi, wr_cfg, flag_set, flag_clr;
    logic [NCH-1:0]    flag_q;
    logic              tick_q;
    logic              split0;
    logic              unused_bits;

    assign unused_bits = ^wr_data[BYTE_W-1:FLAG_BIT+1];
    assign split0      = (cfg_q[0].mode == MODE_SPLIT);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            // Address decode for this channel's bytes and configuration.
            assign wr_lo[i]  = wr_en && (wr_addr == ADDR_W'(2*i));
            assign wr_hi[i]  = wr_en && (wr_addr == ADDR_W'(2*i+1));
            assign wr_cfg[i] = wr_en && (wr_addr == ADDR_W'(2*NCH+i));

            tmr_fall_detect u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .smp_en (mc_en),
                .pin    (ext_cnt[i]),
                .fall   (fall[i])
            );

            // Count enable: run, gate qualification, then source select.
            assign step[i] = cfg_q[i].run
                           && (!cfg_q[i].gate || ext_gate[i])
                           && (cfg_q[i].ext_sel ? fall[i] : mc_en);

            tmr_channel #(
                .BYTE_W    (BYTE_W),
                .PRESC_W   (PRESC_W),
                .HAS_SPLIT (i == 0)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (cfg_q[i].mode),
                .step     (step[i]),
                .aux_step (aux_step[i]),
                .wr_lo    (wr_lo[i]),
                .wr_hi    (wr_hi[i]),
                .wr_data  (wr_data),
                .lo_q     (lo_q[i]),
                .hi_q     (hi_q[i]),
                .wrap     (wrap[i]),
                .aux_wrap (aux_wrap[i])
            );

            // Configuration register.
            always_ff @(posedge clk) begin
                if (!rst_n)         cfg_q[i] <= '0;
                else if (wr_cfg[i]) cfg_q[i] <= tmr_cfg_t'(wr_data[CFG_W-1:0]);
            end

            assign flag_clr[i] = int_ack[i] || (wr_cfg[i] && !wr_data[FLAG_BIT]);

            // Sticky overflow flag; a set in the same cycle beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)           flag_q[i] <= 1'b0;
                else if (flag_set[i]) flag_q[i] <= 1'b1;
                else if (flag_clr[i]) flag_q[i] <= 1'b0;
            end
        end
    endgenerate

    // Split high byte is a pure machine-cycle timer run by channel 1's run bit.
    assign aux_step[0] = split0 && cfg_q[1].run && mc_en;
    assign aux_step[1] = 1'b0;

    // Flag sources: in split mode channel 1's flag follows channel 0's high byte.
    assign flag_set[0] = wrap[0];
    assign flag_set[1] = split0 ? aux_wrap[0] : wrap[1];

    // Tick register: channel 1's own wrap, independent of who owns its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= wrap[1];
    end

    // Register read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(0): rd_data = lo_q[0];
            ADDR_W'(1): rd_data = hi_q[0];
            ADDR_W'(2): rd_data = lo_q[1];
            ADDR_W'(3): rd_data = hi_q[1];
            ADDR_W'(4): begin
                rd_data[CFG_W-1:0] = cfg_q[0];
                rd_data[FLAG_BIT]  = flag_q[0];
            end
            ADDR_W'(5): begin
                rd_data[CFG_W-1:0] = cfg_q[1];
                rd_data[FLAG_BIT]  = flag_q[1];
            end
            default: rd_data = '0;
        endcase
    end

    assign ovf_flag = flag_q;
    assign ch1_tick = tick_q;

    // A set flag stays set while nothing clears it.
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !int_ack[0] && !(wr_cfg[0] && !wr_data[FLAG_BIT]))
        |=> flag_q[0]);

    // A wrap during a clear still leaves the flag set.
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap[0] && int_ack[0]) |=> flag_q[0]);

    // In split mode channel 1's own wrap does not raise its flag.
    assert_split_no_own_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (split0 && wrap[1] && !aux_wrap[0] && !flag_q[1]) |=> !flag_q[1]);

    // The tick is a single-cycle pulse unless channel 1 wraps back to back.
    assert_tick_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && !wrap[1]) |=> !tick_q);

endmodule

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table for channel 0's count modes, then
// directed tests for edges, gating, flags, collisions, split mode and reset.
module sim_tmr_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic [1:0] ext_cnt = '0;
    logic [1:0] ext_gate = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] int_ack = '0;
    logic [1:0] ovf_flag;
    logic       ch1_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_pair u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_en    (mc_en),
        .ext_cnt  (ext_cnt),
        .ext_gate (ext_gate),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .int_ack  (int_ack),
        .ovf_flag (ovf_flag),
        .ch1_tick (ch1_tick)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] n;
        logic [7:0] elo;
        logic [7:0] ehi;
        logic       ef;
    } vec_t;

    // Channel 0, timer source, gate off: mode, start bytes, cycles, expected.
    localparam vec_t VECS [8] = '{
        '{2'd1, 8'hFE, 8'h12, 8'd3, 8'h01, 8'h13, 1'b0},  // R2 carry
        '{2'd1, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},  // R2 wrap
        '{2'd0, 8'h1F, 8'h05, 8'd1, 8'h00, 8'h06, 1'b0},  // R3 prescaler carry
        '{2'd0, 8'hFF, 8'hFF, 8'd1, 8'hE0, 8'h00, 1'b1},  // R3 wrap, top bits kept
        '{2'd0, 8'hE3, 8'h40, 8'd2, 8'hE5, 8'h40, 1'b0},  // R3 plain
        '{2'd2, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 1'b1},  // R4 reload
        '{2'd2, 8'h10, 8'hAA, 8'd5, 8'h15, 8'hAA, 1'b0},  // R4 no reload
        '{2'd1, 8'h00, 8'h00, 8'd0, 8'h00, 8'h00, 1'b0}   // R5 no cycles
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic mc(input int n);
        for (int k = 0; k < n; k++) begin
            mc_en = 1'b1;
            cyc();
            mc_en = 1'b0;
        end
    endtask

    task automatic rdb(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rdb(a, d);
        chk(req, d, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        for (int a = 0; a < 6; a++) chk_reg("R1 reset byte", 3'(a), 8'h00);
        chk("R1 reset flags", {6'b0, ovf_flag}, 8'h00);
        chk("R1 reset tick", {7'b0, ch1_tick}, 8'h00);

        // Vector table: R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            wr(3'd4, 8'h00);
            wr(3'd0, VECS[v].lo);
            wr(3'd1, VECS[v].hi);
            wr(3'd4, {6'b010000, VECS[v].mode} | 8'h10);
            mc(int'(VECS[v].n));
            wr(3'd4, 8'h20 | {6'b0, VECS[v].mode});
            chk_reg($sformatf("vec%0d low byte", v), 3'd0, VECS[v].elo);
            chk_reg($sformatf("vec%0d high byte", v), 3'd1, VECS[v].ehi);
            chk($sformatf("vec%0d flag", v), {7'b0, ovf_flag[0]}, {7'b0, VECS[v].ef});
        end

        // R5: timer source ignores the pin
        wr(3'd4, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        wr(3'd4, 8'h11);
        for (int k = 0; k < 4; k++) begin ext_cnt[0] = ~ext_cnt[0]; cyc(); end
        chk_reg("R5 pin toggles without mc_en", 3'd0, 8'h00);
        ext_cnt[0] = 1'b1; mc(1); ext_cnt[0] = 1'b0; mc(2);
        chk_reg("R5 timer counts mc_en only", 3'd0, 8'h03);

        // R6: counter source needs a 1-then-0 across two samples
        wr(3'd4, 8'h00); wr(3'd0, 8'h00);
        wr(3'd4, 8'h15);
        ext_cnt[0] = 1'b1; mc(1);
        ext_cnt[0] = 1'b0; mc(1);
        chk_reg("R6 one falling edge", 3'd0, 8'h01);
        mc(2);
        chk_reg("R6 steady low no count", 3'd0, 8'h01);
        ext_cnt[0] = 1'b1; cyc(); ext_cnt[0] = 1'b0; mc(1);
        chk_reg("R6 unsampled pulse ignored", 3'd0, 8'h01);
        ext_cnt[0] = 1'b1; mc(1); ext_cnt[0] = 1'b0; cyc(); mc(1);
        chk_reg("R6 late edge counted", 3'd0, 8'h02);

        // R7: gating
        wr(3'd4, 8'h00); wr(3'd0, 8'h00);
        wr(3'd4, 8'h19);
        ext_gate[0] = 1'b0; mc(3);
        chk_reg("R7 gate input low blocks", 3'd0, 8'h00);
        ext_gate[0] = 1'b1; mc(2);
        chk_reg("R7 gate input high counts", 3'd0, 8'h02);
        ext_gate[0] = 1'b0;
        wr(3'd4, 8'h21); mc(3);
        chk_reg("R7 run off blocks", 3'd0, 8'h02);

        // R10: sticky flag, clear paths, set beats clear
        wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'hFF);
        wr(3'd4, 8'h12);
        mc(1);
        chk("R10 flag set on reload wrap", {7'b0, ovf_flag[0]}, 8'h01);
        cyc(); cyc(); cyc();
        chk("R10 flag sticky", {7'b0, ovf_flag[0]}, 8'h01);
        int_ack[0] = 1'b1; cyc(); int_ack[0] = 1'b0;
        chk("R10 ack clears", {7'b0, ovf_flag[0]}, 8'h00);
        wr(3'd0, 8'hFF);
        mc_en = 1'b1; int_ack[0] = 1'b1; cyc(); mc_en = 1'b0; int_ack[0] = 1'b0;
        chk("R10 wrap with ack ends set", {7'b0, ovf_flag[0]}, 8'h01);
        wr(3'd0, 8'hFF);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h12; mc_en = 1'b1;
        cyc();
        wr_en = 1'b0; mc_en = 1'b0;
        chk("R10 wrap with cfg clear ends set", {7'b0, ovf_flag[0]}, 8'h01);
        wr(3'd4, 8'h12);
        chk("R10 cfg write clears", {7'b0, ovf_flag[0]}, 8'h00);

        // R11: write beats increment
        wr(3'd4, 8'h00); wr(3'd0, 8'h05); wr(3'd1, 8'h00);
        wr(3'd4, 8'h11);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h40; mc_en = 1'b1;
        cyc();
        wr_en = 1'b0; mc_en = 1'b0;
        chk_reg("R11 written low byte kept", 3'd0, 8'h40);
        chk_reg("R11 high byte untouched", 3'd1, 8'h00);

        // R13: configuration read-back layout
        wr(3'd5, 8'h1B);
        chk_reg("R13 cfg read back", 3'd5, 8'h1B);
        chk_reg("R13 unused address", 3'd7, 8'h00);
        wr(3'd5, 8'h00);

        // R8 / R9: split mode
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h30); wr(3'd1, 8'h10);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd5, 8'h11);
        wr(3'd4, 8'h07);
        mc(1);
        chk("R9 tick on ch1 wrap", {7'b0, ch1_tick}, 8'h01);
        chk("R9 ch1 own wrap no flag", {7'b0, ovf_flag[1]}, 8'h00);
        chk_reg("R9 ch1 still counts", 3'd2, 8'h00);
        chk_reg("R8 split high byte on ch1 run", 3'd1, 8'h11);
        chk_reg("R8 split low byte idle without run", 3'd0, 8'h30);
        cyc();
        chk("R9 tick one cycle", {7'b0, ch1_tick}, 8'h00);
        wr(3'd1, 8'hFF);
        mc(1);
        chk_reg("R8 split high byte wraps", 3'd1, 8'h00);
        chk("R8 split wrap sets ch1 flag", {7'b0, ovf_flag[1]}, 8'h01);
        chk("R8 split wrap leaves ch0 flag", {7'b0, ovf_flag[0]}, 8'h00);
        wr(3'd4, 8'h17);
        ext_cnt[0] = 1'b1; mc(1);
        ext_cnt[0] = 1'b0; mc(1);
        chk_reg("R8 split low byte counts edges", 3'd0, 8'h31);
        chk_reg("R8 split high byte is timer", 3'd1, 8'h02);
        wr(3'd5, 8'h01);
        mc(2);
        chk_reg("R8 split high byte stops with ch1 run", 3'd1, 8'h02);

        // R12: channel 1 mode 3 holds
        wr(3'd5, 8'h00); wr(3'd2, 8'h55); wr(3'd3, 8'h66);
        wr(3'd5, 8'h13);
        mc(3);
        chk_reg("R12 ch1 low held", 3'd2, 8'h55);
        chk_reg("R12 ch1 high held", 3'd3, 8'h66);

        // R1: reset while active
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        for (int a = 0; a < 6; a++) chk_reg("R1 mid-run reset", 3'(a), 8'h00);
        chk("R1 mid-run flags", {6'b0, ovf_flag}, 8'h00);
        rdb(3'd0, d);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule